// File: doc/BRIEF.md
# Protected Register Unlock Sequencer

This block guards a small group of system-critical control registers (flash programming control, boot-source select and CPU reset control) against stray writes. It watches the register bus for writes to one lock register. Protection opens only when three exact key values arrive at that register in a fixed order. Any other value written there restarts the sequence. The block never stores the protected registers itself. Instead it produces one write-qualify strobe per protected register, and the owners of those registers accept a write only while that strobe is high.

Software reads the lock register to learn whether protection is open. Any write to the lock register while protection is open closes it again. Writes and reads to other addresses do not change the sequence, so a key sequence may be interleaved with other bus traffic.

Top module: `upl_lock_gate`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge) the block is locked: `unlocked` is 0, the lock register reads 0 and every bit of `prot_wr_ok` is 0. A reset in the middle of a key sequence discards the progress made so far.
- R2: The lock register is at offset 0x100. Protection opens only after three writes to it with the full-word values 0x59, then 0x16, then 0x88. `unlocked` goes to 1 in the cycle after the rising edge that captures the third write. A value with any upper bit set (for example 0x100_0059) does not match a key.
- R3: While locked, a write to the lock register whose value is not the next expected key returns the sequence to its start. If that value is 0x59, it counts as the first key, so the sequence then waits for 0x16.
- R4: Writes to any address other than 0x100, including the protected registers, leave the sequence progress and `unlocked` unchanged.
- R5: With `bus_addr` at 0x100, `bus_rdata` returns the unlocked state in bit 0 and zeros in all other bits. At any other address, `bus_rdata` is 0.
- R6: While unlocked, a write of any value to the lock register locks the block from the next cycle on. That write never counts as a first key, even if its value is 0x59.
- R7: `prot_wr_ok[i]` is 1 in a cycle exactly when `bus_wr` is 1, the block is unlocked and `bus_addr` equals protected offset i. The offsets are: bit 0 for flash programming control at 0x0C0, bit 1 for boot-source select at 0x0C4, and bit 2 for CPU reset control at 0x008.
- R8: While locked, a write to a protected register leaves every bit of `prot_wr_ok` at 0, so the register owner ignores the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Register offset of the current access |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for the current address (combinational) |
| unlocked | output | 1 | Protection is open |
| prot_wr_ok | output | 3 | Per-register write qualifier for the protected registers |

## Verification
The assertions take for granted that `bus_addr`, `bus_wr` and `bus_wdata` are stable around each rising edge. They also assume that a strobe held high for one cycle is exactly one write. This means that consecutive key writes are distinct bus beats and never one held strobe. The bench drives every access on the falling edge and releases `bus_wr` after one cycle, which keeps it within those assumptions. It sweeps every byte value at every step of the sequence, including the open state. It also covers wide values with upper bits set, interleaved writes to other addresses and a reset part-way through a sequence.

// File: rtl/upl_pkg.sv
// Package: shared constants for the protected register unlock sequencer.
// Assumes register offsets fit in 12 bits and keys fit in 8 bits.
package upl_pkg;

    localparam int          OFF_W    = 12;
    localparam int          KEY_W    = 8;
    localparam int          PROT_N   = 3;
    localparam int          KEY_N    = 3;
    localparam logic [11:0] LOCK_OFF = 12'h100;

    // Progress through the key: number of keys already matched, or open.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_K1   = 2'd1,
        ST_K2   = 2'd2,
        ST_OPEN = 2'd3
    } seq_state_e;

    // Key value expected at a given step of the sequence.
    function automatic logic [KEY_W-1:0] key_at(input int step);
        case (step)
            0:       return 8'h59;
            1:       return 8'h16;
            default: return 8'h88;
        endcase
    endfunction

    // Offset of protected register i (bit i of the qualifier vector).
    function automatic logic [OFF_W-1:0] prot_off(input int idx);
        case (idx)
            0:       return 12'h0C0;
            1:       return 12'h0C4;
            default: return 12'h008;
        endcase
    endfunction

endpackage

// File: rtl/upl_addr_dec.sv
// Module: address decoder and write qualifier.
// Flags lock-register writes and, per protected register, a write strobe
// that passes only while protection is open. Assumes ADDR_W >= 12.
module upl_addr_dec #(
    parameter int ADDR_W = 12,
    parameter int PROT_N = 3
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              open_i,
    output logic              lock_sel,
    output logic              lock_wr,
    output logic [PROT_N-1:0] prot_wr_ok
);
    import upl_pkg::*;

    // Purpose: select the lock register by exact offset match.
    always_comb begin
        lock_sel = (bus_addr == ADDR_W'(LOCK_OFF));
        lock_wr  = lock_sel && bus_wr;
    end

    // One comparator and gate per protected register.
    for (genvar gi = 0; gi < PROT_N; gi++) begin : g_prot
        // Purpose: pass a protected write only while unlocked.
        always_comb begin
            prot_wr_ok[gi] = bus_wr && open_i &&
                             (bus_addr == ADDR_W'(prot_off(gi)));
        end
    end

endmodule

// File: rtl/upl_key_fsm.sv
// Module: key sequencer.
// Advances on each lock-register write that carries the next key value,
// falls back to the start on any mismatch (a mismatching first key
// restarts at step one), and relocks on any write while open.
// Assumes one write per cycle that lock_wr is high.
module upl_key_fsm #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              open_o
);
    import upl_pkg::*;

    localparam logic [DATA_W-1:0] KEY0 = DATA_W'(key_at(0));
    localparam logic [DATA_W-1:0] KEY1 = DATA_W'(key_at(1));
    localparam logic [DATA_W-1:0] KEY2 = DATA_W'(key_at(2));

    seq_state_e state_q, state_d;

    // Purpose: pick the next step from the current step and written value.
    always_comb begin
        state_d = state_q;
        if (lock_wr) begin
            unique case (state_q)
                ST_IDLE: state_d = (wdata == KEY0) ? ST_K1 : ST_IDLE;
                ST_K1:   state_d = (wdata == KEY1) ? ST_K2 :
                                   (wdata == KEY0) ? ST_K1 : ST_IDLE;
                ST_K2:   state_d = (wdata == KEY2) ? ST_OPEN :
                                   (wdata == KEY0) ? ST_K1 : ST_IDLE;
                ST_OPEN: state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Purpose: hold sequence progress; reset to the locked start step.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Purpose: open exactly when the final key has been accepted.
    always_comb open_o = (state_q == ST_OPEN);

endmodule

// File: rtl/upl_rd_mux.sv
// Module: read-back mux for the lock register.
// Returns the open flag in bit 0 at the lock offset, zero elsewhere.
// Assumes reads have no side effects.
module upl_rd_mux #(
    parameter int DATA_W = 32
) (
    input  logic              lock_sel,
    input  logic              open_i,
    output logic [DATA_W-1:0] rdata
);
    // Purpose: drive status at the lock offset, zeros elsewhere.
    always_comb begin
        rdata = '0;
        if (lock_sel) rdata[0] = open_i;
    end

endmodule

// File: rtl/upl_lock_gate.sv
// Module: protected register unlock sequencer, top level.
// Joins the address decoder, the key sequencer and the read mux. The
// protected registers live elsewhere and accept writes only on
// prot_wr_ok. Assumes a single-beat register bus, one write per cycle.
module upl_lock_gate #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int PROT_N = upl_pkg::PROT_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              unlocked,
    output logic [PROT_N-1:0] prot_wr_ok
);
    logic lock_sel;
    logic lock_wr;
    logic open_w;

    upl_addr_dec #(.ADDR_W(ADDR_W), .PROT_N(PROT_N)) dec_i (
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .open_i     (open_w),
        .lock_sel   (lock_sel),
        .lock_wr    (lock_wr),
        .prot_wr_ok (prot_wr_ok)
    );

    upl_key_fsm #(.DATA_W(DATA_W)) fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock_wr (lock_wr),
        .wdata   (bus_wdata),
        .open_o  (open_w)
    );

    upl_rd_mux #(.DATA_W(DATA_W)) rd_i (
        .lock_sel (lock_sel),
        .open_i   (open_w),
        .rdata    (bus_rdata)
    );

    // Purpose: expose the open flag as the unlocked status.
    always_comb unlocked = open_w;

endmodule

// File: rtl/upl_lock_gate_chk.sv
// Module: assertion checker for upl_lock_gate, bound to every instance.
// Observes only the top-level ports.
module upl_lock_gate_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int PROT_N = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              unlocked,
    input logic [PROT_N-1:0] prot_wr_ok
);
    import upl_pkg::*;

    localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(LOCK_OFF);
    localparam logic [DATA_W-1:0] LAST_K = DATA_W'(key_at(2));

    // R1: the first cycle out of reset is locked.
    a_r1_reset_locked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !unlocked);

    // R2: opening is always caused by a final-key write to the lock offset.
    a_r2_open_by_last_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(bus_wr && bus_addr == LOCK_A && bus_wdata == LAST_K));

    // R4: writes elsewhere do not change the unlocked state.
    a_r4_other_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != LOCK_A) |=> $stable(unlocked));

    // R6: any lock-register write while open relocks.
    a_r6_relock: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && bus_wr && bus_addr == LOCK_A) |=> !unlocked);

    // R7: at most one protected register is qualified per cycle.
    a_r7_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(prot_wr_ok));

    // R8: no protected write passes while locked.
    a_r8_locked_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |-> (prot_wr_ok == '0));

endmodule

bind upl_lock_gate upl_lock_gate_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PROT_N (PROT_N)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .unlocked   (unlocked),
    .prot_wr_ok (prot_wr_ok)
);

// File: tb/upl_lock_gate_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps every byte value at every sequence step against a
// step model written from the requirements.
module upl_lock_gate_tb_top;

    localparam logic [11:0] LOCK = 12'h100;
    localparam logic [11:0] PA0  = 12'h0C0;
    localparam logic [11:0] PA1  = 12'h0C4;
    localparam logic [11:0] PA2  = 12'h008;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        unlocked;
    logic [2:0]  prot_wr_ok;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    upl_lock_gate dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .unlocked   (unlocked),
        .prot_wr_ok (prot_wr_ok)
    );

    function automatic logic [31:0] kv(input int i);
        return (i == 0) ? 32'h59 : (i == 1) ? 32'h16 : 32'h88;
    endfunction

    // Step model: 0..2 keys matched, 3 = open.
    function automatic int mstep(input int s, input logic [31:0] v);
        if (s == 3)      return 0;
        if (v == kv(s))  return s + 1;
        if (v == 32'h59) return 1;
        return 0;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic goto_step(input int s);
        wr(LOCK, 32'h0);
        for (int k = 0; k < s; k++) wr(LOCK, kv(k));
    endtask

    // Present a protected write and compare the qualifier before the edge.
    task automatic probe(input logic [11:0] a, input logic [2:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1;
        #1;
        chk(prot_wr_ok == exp, tag, {29'd0, prot_wr_ok}, {29'd0, exp});
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1;
        chk(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        @(negedge clk);
        chk(unlocked == 1'b0, "R1 unlocked after reset", {31'd0, unlocked}, 32'd0);
        rd_chk(LOCK, 32'd0, "R1 lock readback after reset");
        probe(PA0, 3'b000, "R1/R8 qualifier after reset");

        // R3 sweep: every byte value at every step, then complete the key.
        for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < 256; v++) begin
                int m;
                goto_step(s);
                wr(LOCK, 32'(v));
                m = mstep(s, 32'(v));
                chk(unlocked == (m == 3), $sformatf("R3 step %0d value 0x%0h", s, v),
                    {31'd0, unlocked}, {31'd0, m == 3});
                probe(PA1, (m == 3) ? 3'b010 : 3'b000,
                      $sformatf("R7/R8 qualifier step %0d value 0x%0h", s, v));
                for (int k = m; k < 3; k++) wr(LOCK, kv(k));
                chk(unlocked == 1'b1, $sformatf("R2/R3 completion from step %0d value 0x%0h", s, v),
                    {31'd0, unlocked}, 32'd1);
            end
        end

        // R2: upper bits set do not match
        goto_step(0);
        wr(LOCK, 32'h0100_0059); wr(LOCK, 32'h16); wr(LOCK, 32'h88);
        chk(unlocked == 1'b0, "R2 wide first key", {31'd0, unlocked}, 32'd0);
        goto_step(2);
        wr(LOCK, 32'hFF00_0088);
        chk(unlocked == 1'b0, "R2 wide last key", {31'd0, unlocked}, 32'd0);

        // R4: interleaved writes elsewhere
        goto_step(1);
        wr(PA0, 32'h16); wr(12'h104, 32'h16); wr(LOCK, 32'h16);
        wr(PA2, 32'h88); wr(12'h2F0, 32'h59); wr(LOCK, 32'h88);
        chk(unlocked == 1'b1, "R4 interleaved sequence opens", {31'd0, unlocked}, 32'd1);
        wr(12'h0FC, 32'h0); wr(PA1, 32'h0);
        chk(unlocked == 1'b1, "R4 other writes keep open", {31'd0, unlocked}, 32'd1);

        // R5/R7: readback and qualifiers while open
        rd_chk(LOCK, 32'd1, "R5 lock readback open");
        rd_chk(PA0, 32'd0, "R5 other address reads zero");
        probe(PA0, 3'b001, "R7 flash control qualifier");
        probe(PA1, 3'b010, "R7 boot select qualifier");
        probe(PA2, 3'b100, "R7 CPU reset qualifier");
        probe(12'h0C8, 3'b000, "R7 unprotected address");

        // R6: relock with 0x59 does not count as a first key
        wr(LOCK, 32'h59);
        chk(unlocked == 1'b0, "R6 relock", {31'd0, unlocked}, 32'd0);
        rd_chk(LOCK, 32'd0, "R5 lock readback locked");
        wr(LOCK, 32'h16); wr(LOCK, 32'h88);
        chk(unlocked == 1'b0, "R6 relock value not first key", {31'd0, unlocked}, 32'd0);

        // R8: protected writes blocked while locked
        probe(PA0, 3'b000, "R8 flash control blocked");
        probe(PA2, 3'b000, "R8 CPU reset blocked");

        // R1: reset mid-sequence discards progress
        goto_step(2);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        wr(LOCK, 32'h88);
        chk(unlocked == 1'b0, "R1 reset discards progress", {31'd0, unlocked}, 32'd0);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule